// File: doc/BRIEF.md
# Two-Stage UART Baud Rate Generator

This block derives the two timing enables a UART needs from a single reference clock. It produces an oversampling enable (`sample_tick`) and a bit-rate enable (`baud_tick`). Both are one-cycle pulses in the reference clock domain, so every downstream engine stays on that clock and uses the pulses as clock enables.

Timing is built in three stages. A selectable prescaler passes every reference cycle, or one cycle in eight. A sample divider counts those prescaled cycles and fires once every CD of them. A bit divider counts sample pulses and fires once every BDIV+1 of them. The bit rate is therefore the selected rate divided by CD·(BDIV+1).

The prescale select, CD and BDIV inputs take effect only on a cycle where `load` is high. That same load restarts every counter, so the first pulses after a reconfiguration come exactly one full period later.

Top module: `uart_baud_gen`

## Requirements
- R1: While `rst` is high, and after reset until the first `load`, both `sample_tick` and `baud_tick` stay low. Reset leaves CD at 0, which means disabled.
- R2: With `prescale_div8` = 0 loaded and a loaded CD ≥ 2, `sample_tick` is a one-cycle pulse. It rises every CD clock cycles.
- R3: With `prescale_div8` = 1 loaded, `sample_tick` rises every 8·CD clock cycles.
- R4: `baud_tick` is a one-cycle pulse. It occurs every CD·(BDIV+1) selected clocks and always coincides with a `sample_tick` pulse.
- R5: A loaded BDIV below 4 acts as 4, so a bit period never spans fewer than 5 sample pulses.
- R6: A loaded CD of 0 or 1 stops both `sample_tick` and `baud_tick`.
- R7: `load` restarts all counters and suppresses any partial period. Both outputs are low in the cycle after a load. The first `sample_tick` comes P·CD cycles after the load edge, where P is 1 or 8. The first `baud_tick` comes P·CD·(BDIV+1) cycles after it.
- R8: Changes on `cd_in`, `bdiv_in` and `prescale_div8` while `load` is low have no effect on the pulse timing.
- R9: The full 8-bit BDIV range is honoured. BDIV = 255 with CD = 2 and no prescale gives a `baud_tick` every 512 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| prescale_div8 | input | 1 | 1 selects reference/8, 0 selects reference directly (captured on load) |
| cd_in | input | 16 | Sample divisor CD (captured on load) |
| bdiv_in | input | 8 | Bit divisor BDIV (captured on load) |
| load | input | 1 | Captures the configuration and restarts all counters |
| sample_tick | output | 1 | One-cycle oversampling enable |
| baud_tick | output | 1 | One-cycle bit-rate enable |

## Verification
The bench aims at the boundaries of the dividers.

- **Minimum CD of 2.** An off-by-one sample counter would show a period of 1 or 3 here.
- **CD of 0 and 1.** A design without the disable would emit a tick every cycle or wrap its counter through 65535.
- **BDIV values below 4.** A missing clamp would shorten the bit period to fewer than five samples.
- **Full BDIV range.** An 8-bit compare that truncates would fire early.
- **Loads in the middle of a period, and divisor changes without a load.** A divider that kept its count across a reload would emit a short first period. One that read its inputs live would drift to the new rate without any load.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
  // Prescaler selection encoding as seen on the prescale_div8 port.
  typedef enum logic {
    PRE_BYPASS = 1'b0,
    PRE_DIVIDE = 1'b1
  } pre_mode_e;

  localparam int CD_W_DEF    = 16;
  localparam int BDIV_W_DEF  = 8;
  localparam int PRE_DIV_DEF = 8;
  localparam int BDIV_MIN_DEF = 4;
endpackage

// File: rtl/bg_prescaler.sv
module bg_prescaler #(
  parameter int PRE_DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic div_on,
  output logic step_en
);
  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

  generate
    if (PRE_DIV > 1) begin : g_div
      logic [PW-1:0] cnt;
      logic          wrap;

      assign wrap = (cnt == PW'(PRE_DIV - 1));

      always_ff @(posedge clk) begin
        if (rst || clr || !div_on) begin
          cnt <= '0;
        end else if (wrap) begin
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end

      assign step_en = !div_on || wrap;
    end else begin : g_bypass
      assign step_en = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/bg_sample_div.sv
module bg_sample_div #(
  parameter int CD_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            step_en,
  input  logic [CD_W-1:0] cd,
  output logic            active,
  output logic            fire
);
  logic [CD_W-1:0] cnt;
  logic [CD_W-1:0] last;

  assign active = (cd >= CD_W'(2));
  assign last   = cd - 1'b1;
  assign fire   = active && step_en && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || clr || !active) begin
      cnt <= '0;
    end else if (step_en) begin
      if (fire) cnt <= '0;
      else      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/bg_bit_div.sv
module bg_bit_div #(
  parameter int BDIV_W   = 8,
  parameter int BDIV_MIN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              step,
  input  logic [BDIV_W-1:0] bdiv,
  output logic              fire
);
  logic [BDIV_W-1:0] cnt;
  logic [BDIV_W-1:0] beff;

  assign beff = (bdiv < BDIV_W'(BDIV_MIN)) ? BDIV_W'(BDIV_MIN) : bdiv;
  assign fire = step && (cnt == beff);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (step) begin
      if (fire) cnt <= '0;
      else      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
  import baud_gen_pkg::*;
#(
  parameter int CD_W     = CD_W_DEF,
  parameter int BDIV_W   = BDIV_W_DEF,
  parameter int PRE_DIV  = PRE_DIV_DEF,
  parameter int BDIV_MIN = BDIV_MIN_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prescale_div8,
  input  logic [CD_W-1:0]   cd_in,
  input  logic [BDIV_W-1:0] bdiv_in,
  input  logic              load,
  output logic              sample_tick,
  output logic              baud_tick
);
  pre_mode_e         mode_q;
  logic [CD_W-1:0]   cd_q;
  logic [BDIV_W-1:0] bdiv_q;
  logic              pre_en;
  logic              smp_active;
  logic              smp_fire;
  logic              bit_fire;

  // Configuration capture; only a load changes it.
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= PRE_BYPASS;
      cd_q   <= '0;
      bdiv_q <= '0;
    end else if (load) begin
      mode_q <= pre_mode_e'(prescale_div8);
      cd_q   <= cd_in;
      bdiv_q <= bdiv_in;
    end
  end

  bg_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .clr     (load),
    .div_on  (mode_q == PRE_DIVIDE),
    .step_en (pre_en)
  );

  bg_sample_div #(.CD_W(CD_W)) u_smp (
    .clk     (clk),
    .rst     (rst),
    .clr     (load),
    .step_en (pre_en),
    .cd      (cd_q),
    .active  (smp_active),
    .fire    (smp_fire)
  );

  bg_bit_div #(.BDIV_W(BDIV_W), .BDIV_MIN(BDIV_MIN)) u_bit (
    .clk   (clk),
    .rst   (rst),
    .clr   (load),
    .step  (smp_fire),
    .bdiv  (bdiv_q),
    .fire  (bit_fire)
  );

  // Registered pulse outputs.
  always_ff @(posedge clk) begin
    if (rst || load) begin
      sample_tick <= 1'b0;
      baud_tick   <= 1'b0;
    end else begin
      sample_tick <= smp_fire;
      baud_tick   <= bit_fire && smp_active;
    end
  end
endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk #(
  parameter int CD_W     = 16,
  parameter int BDIV_MIN = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            load,
  input logic [CD_W-1:0] cd_cfg,
  input logic            sample_tick,
  input logic            baud_tick
);
  logic [15:0] samp_since;

  always_ff @(posedge clk) begin
    if (rst || load || baud_tick) samp_since <= '0;
    else if (sample_tick)         samp_since <= samp_since + 1'b1;
  end

  // R4: bit pulse only together with a sample pulse
  p_baud_on_sample_r4: assert property (@(posedge clk) disable iff (rst)
    baud_tick |-> sample_tick);

  // R2: sample pulse lasts one cycle
  p_sample_single_r2: assert property (@(posedge clk) disable iff (rst)
    sample_tick |=> !sample_tick);

  // R6: a disabled sample divisor keeps both outputs quiet
  p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (cd_cfg < CD_W'(2)) |-> (!sample_tick && !baud_tick));

  // R7: a load suppresses pulses in the following cycle
  p_load_clears_r7: assert property (@(posedge clk) disable iff (rst)
    load |=> (!sample_tick && !baud_tick));

  // R5: at least BDIV_MIN samples precede the one carrying a bit pulse
  p_min_samples_r5: assert property (@(posedge clk) disable iff (rst)
    baud_tick |-> (samp_since >= 16'(BDIV_MIN)));
endmodule

bind uart_baud_gen baud_gen_chk #(.CD_W(CD_W), .BDIV_MIN(BDIV_MIN)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .load        (load),
  .cd_cfg      (cd_q),
  .sample_tick (sample_tick),
  .baud_tick   (baud_tick)
);

// File: tb/uart_baud_gen_bench.sv
`timescale 1ns/1ps
module uart_baud_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        prescale_div8 = 1'b0;
  logic [15:0] cd_in = '0;
  logic [7:0]  bdiv_in = '0;
  logic        load = 1'b0;
  logic        sample_tick;
  logic        baud_tick;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc_total = 0;
  bit    started = 0;
  bit    done = 0;
  string cur_req = "R1";

  // reference model state
  int m_cd = 0, m_bd = 0, m_sel = 0, m_cyc = 0;

  always #2.5 clk = ~clk;

  uart_baud_gen u_uart_baud_gen (
    .clk(clk), .rst(rst), .prescale_div8(prescale_div8), .cd_in(cd_in),
    .bdiv_in(bdiv_in), .load(load), .sample_tick(sample_tick), .baud_tick(baud_tick)
  );

  always @(posedge clk) begin
    started <= 1'b1;
    cyc_total <= cyc_total + 1;
    if (rst) begin
      m_cd = 0; m_bd = 0; m_sel = 0; m_cyc = 0;
    end else if (load) begin
      m_cd = cd_in; m_bd = bdiv_in; m_sel = prescale_div8; m_cyc = 0;
    end else begin
      m_cyc = m_cyc + 1;
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      int  p, sp, beff;
      bit  es, eb;
      p    = m_sel ? 8 : 1;
      sp   = p * m_cd;
      beff = (m_bd < 4) ? 4 : m_bd;
      es   = (m_cd >= 2) && (m_cyc > 0) && (m_cyc % sp == 0);
      eb   = es && (m_cyc % (sp * (beff + 1)) == 0);
      n_cmp = n_cmp + 2;
      if (sample_tick !== es) begin
        n_bad++;
        $display("FAIL %s sample_tick t=%0t actual=%b expected=%b", cur_req, $time, sample_tick, es);
      end
      if (baud_tick !== eb) begin
        n_bad++;
        $display("FAIL %s baud_tick t=%0t actual=%b expected=%b", cur_req, $time, baud_tick, eb);
      end
    end
  end

  always @(negedge clk) begin
    if (!done && cyc_total > 100000) begin
      n_bad++;
      done = 1;
      $display("FAIL watchdog expired actual=%0d cycles expected<100000", cyc_total);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_load(input bit sel, input int cd, input int bd);
    @(negedge clk);
    prescale_div8 = sel; cd_in = 16'(cd); bdiv_in = 8'(bd); load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  initial begin
    cur_req = "R1";                 // reset holds outputs low, CD disabled
    run(5);
    rst = 1'b0;
    cd_in = 16'd3; bdiv_in = 8'd4;   // no load: still disabled
    run(40);

    cur_req = "R2";                 // CD=3, no prescale
    do_load(1'b0, 3, 4);
    run(60);

    cur_req = "R4";                 // CD=4, BDIV=6: baud every 28
    do_load(1'b0, 4, 6);
    run(120);

    cur_req = "R5";                 // BDIV=1 clamps to 4
    do_load(1'b0, 5, 1);
    run(80);
    do_load(1'b0, 2, 0);
    run(40);

    cur_req = "R3";                 // prescale by 8, CD=2, BDIV=5
    do_load(1'b1, 2, 5);
    run(300);

    cur_req = "R6";                 // CD=1 and CD=0 disable both
    do_load(1'b0, 1, 4);
    run(40);
    do_load(1'b1, 0, 7);
    run(40);

    cur_req = "R8";                 // inputs change without load
    do_load(1'b0, 4, 4);
    run(13);
    cd_in = 16'd9; bdiv_in = 8'd2; prescale_div8 = 1'b1;
    run(100);

    cur_req = "R7";                 // reloads in mid-period
    do_load(1'b0, 6, 4);
    run(17);
    do_load(1'b0, 6, 4);
    run(23);
    do_load(1'b1, 3, 4);
    run(50);
    do_load(1'b0, 3, 5);
    run(60);

    cur_req = "R9";                 // full BDIV range
    do_load(1'b0, 2, 255);
    run(1100);

    cur_req = "R1";                 // reset mid-run returns to disabled
    rst = 1'b1;
    run(3);
    rst = 1'b0;
    run(30);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule